// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

A full-duplex asynchronous serial port controlled through a byte-wide register interface. A transmitter turns a byte written by software into a frame on `txd`: a low start bit, the data, an optional parity bit and one or two high stop bits. A receiver watches `rxd` for a falling edge and confirms the start bit at its midpoint. It then shifts in the data and parity, checks the first stop bit, and places the result in a receive data register. Status flags and two interrupt outputs report progress and errors.

Every bit lasts sixteen ticks of an oversampling clock. That clock comes from one of three sources, picked at run time: an internal programmable divider, rising edges on an external clock pin, or single-cycle pulses from a separate reload timer. The frame format is also set at run time. This covers the data length (7 or 8 bits), the stop count (1 or 2), parity (none, even, odd) and bit order (LSB or MSB first).

Register map (3-bit address): 0 = source select, 1 = divider, 2 = frame control, 3 = status, 4 = data (a write loads transmit data, a read returns receive data).

Top module: `async_serial_port`

## Requirements
- R1: After reset the status register (address 3) reads 0x08, the control register (address 2) reads 0x20, the source register reads 0x00, `txd` is high and both interrupt outputs are low.
- R2: Address 0 bits [1:0] pick the oversampling tick: 0 is the internal divider, giving one tick every (address 1 value + 1) clocks; 1 is each rising edge of `ext_clk`; 2 is each `tmr_tick` pulse. Every serial bit lasts 16 ticks.
- R3: With control bit 0 (transmit enable) set, writing address 4 starts a frame without further action. The frame is a low start bit, then the data bits, then the optional parity bit, then high stop bits.
- R4: Control bit 5 picks 8 data bits when set and 7 when clear. Control bit 4 picks two stop bits when set and one when clear. Both settings apply to transmit and receive.
- R5: Control bit 2 enables parity and control bit 3 selects odd parity when set (even when clear). The transmitter appends the parity bit and the receiver checks it.
- R6: Status bit 0 sends and receives the most significant data bit first when set, and the least significant bit first when clear.
- R7: Status bit 3 (transmit empty) is set at reset and when the data moves into the shift register, and is cleared by a write to address 4. `tx_irq` equals transmit empty AND status bit 2.
- R8: A received frame is stored in the data register and sets status bit 4 (receive full). Reading address 4 clears receive full. `rx_irq` equals receive full AND status bit 1.
- R9: A low level on `rxd` that has ended by the midpoint of the start bit is discarded, and the receiver returns to idle without storing data.
- R10: Status bit 6 (framing) is set when the first stop bit samples low. Bit 7 (parity) is set on a parity mismatch. Bit 5 (overrun) is set when a frame completes while receive full is still set, and the newer byte replaces the stored one. Writing 1 to control bit 6 clears all three flags.
- R11: `txd` stays high while transmission is disabled or no frame is in progress. With control bit 1 (receive enable) clear, traffic on `rxd` does not change the receive flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects on address 4) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address |
| ext_clk | input | 1 | External oversampling clock pin |
| tmr_tick | input | 1 | Single-cycle tick from the reload timer |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The properties assume the following about the inputs:
- The frame format, bit order and enables do not change while a frame is in flight.
- `ext_clk` toggles no faster than once every two system clocks.
- `tmr_tick` arrives as single-cycle pulses.
- The error clear and the completion of a received frame never fall in the same cycle.

The stimulus keeps to these limits. It changes configuration only between frames, drives the external clock with an eight-clock period and pulses the timer once every three clocks. It holds every bit it drives on `rxd` for exactly sixteen ticks of the selected source.

// File: rtl/ser_pkg.sv
package ser_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int OVS_W  = 4;     // 16x oversampling
    localparam int IDX_W  = $clog2(DATA_W);

    localparam logic [ADDR_W-1:0] A_SRC  = 3'd0;
    localparam logic [ADDR_W-1:0] A_DIV  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd2;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd3;
    localparam logic [ADDR_W-1:0] A_DATA = 3'd4;

    typedef enum logic [1:0] {
        SRC_DIV = 2'd0,
        SRC_PIN = 2'd1,
        SRC_TMR = 2'd2,
        SRC_OFF = 2'd3
    } tick_src_e;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_START,
        FS_DATA,
        FS_PAR,
        FS_STOP
    } frame_st_e;

    typedef struct packed {
        logic eight;
        logic par_en;
        logic par_odd;
        logic two_stop;
        logic msb_first;
    } frame_cfg_t;

    function automatic logic calc_par(input logic [DATA_W-1:0] d, input frame_cfg_t c);
        logic [DATA_W-1:0] m;
        m = c.eight ? d : {1'b0, d[DATA_W-2:0]};
        return (^m) ^ c.par_odd;
    endfunction

    function automatic logic [IDX_W-1:0] last_idx(input frame_cfg_t c);
        return c.eight ? IDX_W'(DATA_W - 1) : IDX_W'(DATA_W - 2);
    endfunction

    function automatic logic [IDX_W-1:0] line_pos(input logic [IDX_W-1:0] idx, input frame_cfg_t c);
        return c.msb_first ? (last_idx(c) - idx) : idx;
    endfunction

endpackage

// File: rtl/ser_tick_sel.sv
module ser_tick_sel
    import ser_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  tick_src_e        src,
    input  logic [DIV_W-1:0] div,
    input  logic             ext_clk,
    input  logic             tmr_tick,
    output logic             tick
);
    localparam int SYNC_N = 3;

    logic [DIV_W-1:0]  div_cnt;
    logic [SYNC_N-1:0] pin_sync;
    logic              div_hit;
    logic              pin_rise;

    assign div_hit  = (div_cnt >= div);
    assign pin_rise = pin_sync[SYNC_N-2] & ~pin_sync[SYNC_N-1];

    always_ff @(posedge clk) begin
        if (rst || src != SRC_DIV || div_hit) div_cnt <= '0;
        else                                  div_cnt <= div_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) pin_sync <= '0;
        else     pin_sync <= {pin_sync[SYNC_N-2:0], ext_clk};
    end

    always_comb begin
        case (src)
            SRC_DIV: tick = div_hit;
            SRC_PIN: tick = pin_rise;
            SRC_TMR: tick = tmr_tick;
            default: tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/ser_tx.sv
module ser_tx
    import ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tick,
    input  logic              pending,
    input  logic [DATA_W-1:0] data,
    input  frame_cfg_t        cfg,
    output logic              load,
    output logic              busy,
    output logic              txd
);
    frame_st_e         st;
    logic [OVS_W-1:0]  ovs;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] sh;
    frame_cfg_t        cq;
    logic              bit_end;

    assign load    = en && pending && (st == FS_IDLE);
    assign busy    = (st != FS_IDLE);
    assign bit_end = tick && (ovs == '1);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st  <= FS_IDLE;
            ovs <= '0;
            idx <= '0;
            sh  <= '0;
            cq  <= '0;
        end else begin
            if (st == FS_IDLE) begin
                if (pending) begin
                    st  <= FS_START;
                    ovs <= '0;
                    idx <= '0;
                    sh  <= data;
                    cq  <= cfg;
                end
            end else if (tick) begin
                ovs <= ovs + 1'b1;
                if (bit_end) begin
                    case (st)
                        FS_START: begin
                            st  <= FS_DATA;
                            idx <= '0;
                        end
                        FS_DATA: begin
                            if (idx == last_idx(cq)) begin
                                st  <= cq.par_en ? FS_PAR : FS_STOP;
                                idx <= '0;
                            end else begin
                                idx <= idx + 1'b1;
                            end
                        end
                        FS_PAR: begin
                            st  <= FS_STOP;
                            idx <= '0;
                        end
                        FS_STOP: begin
                            if (cq.two_stop && idx == '0) idx <= idx + 1'b1;
                            else                          st  <= FS_IDLE;
                        end
                        default: st <= FS_IDLE;
                    endcase
                end
            end
        end
    end

    always_comb begin
        case (st)
            FS_START: txd = 1'b0;
            FS_DATA:  txd = sh[line_pos(idx, cq)];
            FS_PAR:   txd = calc_par(sh, cq);
            default:  txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/ser_rx.sv
module ser_rx
    import ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tick,
    input  logic              rxd,
    input  frame_cfg_t        cfg,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              perr,
    output logic              ferr
);
    localparam logic [OVS_W-1:0] MID = OVS_W'((1 << OVS_W) / 2 - 1);

    logic [1:0]        sync;
    logic              rs;
    frame_st_e         st;
    logic [OVS_W-1:0]  ovs;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] buf_q;
    logic              par_q;
    frame_cfg_t        cq;
    logic              sample;

    assign rs     = sync[1];
    assign sample = tick && (ovs == '1);

    always_ff @(posedge clk) begin
        if (rst) sync <= 2'b11;
        else     sync <= {sync[0], rxd};
    end

    always_ff @(posedge clk) begin
        done <= 1'b0;
        if (rst || !en) begin
            st    <= FS_IDLE;
            ovs   <= '0;
            idx   <= '0;
            buf_q <= '0;
            par_q <= 1'b0;
            cq    <= '0;
            data  <= '0;
            perr  <= 1'b0;
            ferr  <= 1'b0;
        end else begin
            case (st)
                FS_IDLE: begin
                    if (!rs) begin
                        st    <= FS_START;
                        ovs   <= '0;
                        idx   <= '0;
                        buf_q <= '0;
                        cq    <= cfg;
                    end
                end
                FS_START: begin
                    if (tick) begin
                        if (ovs == MID) begin
                            ovs <= '0;
                            st  <= rs ? FS_IDLE : FS_DATA;
                        end else begin
                            ovs <= ovs + 1'b1;
                        end
                    end
                end
                FS_DATA: begin
                    if (tick) ovs <= ovs + 1'b1;
                    if (sample) begin
                        buf_q[line_pos(idx, cq)] <= rs;
                        if (idx == last_idx(cq)) begin
                            st <= cq.par_en ? FS_PAR : FS_STOP;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                FS_PAR: begin
                    if (tick) ovs <= ovs + 1'b1;
                    if (sample) begin
                        par_q <= rs;
                        st    <= FS_STOP;
                    end
                end
                FS_STOP: begin
                    if (tick) ovs <= ovs + 1'b1;
                    if (sample) begin
                        done <= 1'b1;
                        data <= buf_q;
                        ferr <= !rs;
                        perr <= cq.par_en && (par_q != calc_par(buf_q, cq));
                        st   <= FS_IDLE;
                    end
                end
                default: st <= FS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/async_serial_port.sv
module async_serial_port
    import ser_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int DIV_RESET = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              ext_clk,
    input  logic              tmr_tick,
    input  logic              rxd,
    output logic              txd,
    output logic              rx_irq,
    output logic              tx_irq
);
    tick_src_e         src_q;
    logic [DIV_W-1:0]  div_q;
    logic              tx_en, rx_en;
    logic              rx_ie, tx_ie;
    frame_cfg_t        cfg;
    logic [DATA_W-1:0] tx_hold, rx_hold;
    logic              tx_empty, rx_full;
    logic              ovr, ferr, perr;

    logic              tick, tx_load, tx_busy;
    logic              rx_done, rx_perr, rx_ferr;
    logic [DATA_W-1:0] rx_word;
    logic              wr_ctrl, wr_data, rd_data, clr_err;

    assign wr_ctrl = wr_en && addr == A_CTRL;
    assign wr_data = wr_en && addr == A_DATA;
    assign rd_data = rd_en && addr == A_DATA;
    assign clr_err = wr_ctrl && wdata[6];

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q   <= SRC_DIV;
            div_q   <= DIV_W'(DIV_RESET);
            tx_en   <= 1'b0;
            rx_en   <= 1'b0;
            cfg     <= '{eight: 1'b1, default: 1'b0};
            rx_ie   <= 1'b0;
            tx_ie   <= 1'b0;
            tx_hold <= '0;
        end else if (wr_en) begin
            case (addr)
                A_SRC:  src_q <= tick_src_e'(wdata[1:0]);
                A_DIV:  div_q <= wdata[DIV_W-1:0];
                A_CTRL: begin
                    tx_en        <= wdata[0];
                    rx_en        <= wdata[1];
                    cfg.par_en   <= wdata[2];
                    cfg.par_odd  <= wdata[3];
                    cfg.two_stop <= wdata[4];
                    cfg.eight    <= wdata[5];
                end
                A_STAT: begin
                    cfg.msb_first <= wdata[0];
                    rx_ie         <= wdata[1];
                    tx_ie         <= wdata[2];
                end
                A_DATA: tx_hold <= wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_empty <= 1'b1;
        end else begin
            if (tx_load) tx_empty <= 1'b1;
            if (wr_data) tx_empty <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_hold <= '0;
            rx_full <= 1'b0;
            ovr     <= 1'b0;
            ferr    <= 1'b0;
            perr    <= 1'b0;
        end else begin
            if (clr_err) begin
                ovr  <= 1'b0;
                ferr <= 1'b0;
                perr <= 1'b0;
            end
            if (rx_done) begin
                rx_hold <= rx_word;
                rx_full <= 1'b1;
                ovr     <= ovr | rx_full;
                ferr    <= ferr | rx_ferr;
                perr    <= perr | rx_perr;
            end else if (rd_data) begin
                rx_full <= 1'b0;
            end
        end
    end

    always_comb begin
        case (addr)
            A_SRC:   rdata = {6'd0, src_q};
            A_DIV:   rdata = DATA_W'(div_q);
            A_CTRL:  rdata = {2'b00, cfg.eight, cfg.two_stop, cfg.par_odd, cfg.par_en, rx_en, tx_en};
            A_STAT:  rdata = {perr, ferr, ovr, rx_full, tx_empty, tx_ie, rx_ie, cfg.msb_first};
            A_DATA:  rdata = rx_hold;
            default: rdata = '0;
        endcase
    end

    assign tx_irq = tx_empty && tx_ie;
    assign rx_irq = rx_full && rx_ie;

    ser_tick_sel #(.DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .src      (src_q),
        .div      (div_q),
        .ext_clk  (ext_clk),
        .tmr_tick (tmr_tick),
        .tick     (tick)
    );

    ser_tx u_tx (
        .clk     (clk),
        .rst     (rst),
        .en      (tx_en),
        .tick    (tick),
        .pending (!tx_empty),
        .data    (tx_hold),
        .cfg     (cfg),
        .load    (tx_load),
        .busy    (tx_busy),
        .txd     (txd)
    );

    ser_rx u_rx (
        .clk  (clk),
        .rst  (rst),
        .en   (rx_en),
        .tick (tick),
        .rxd  (rxd),
        .cfg  (cfg),
        .done (rx_done),
        .data (rx_word),
        .perr (rx_perr),
        .ferr (rx_ferr)
    );

endmodule

// File: rtl/ser_port_chk.sv
module ser_port_chk (
    input logic clk,
    input logic rst,
    input logic txd,
    input logic tx_busy,
    input logic tx_empty,
    input logic tx_irq,
    input logic rx_full,
    input logic rx_done,
    input logic rx_irq,
    input logic rd_data,
    input logic clr_err,
    input logic ovr,
    input logic ferr,
    input logic perr
);
    // R7
    tx_load_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_busy) |-> $past(!tx_empty));

    // R7
    tx_irq_chk: assert property (@(posedge clk) disable iff (rst)
        tx_irq |-> tx_empty);

    // R11
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> txd);

    // R8
    rx_store_chk: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> rx_full);

    // R8
    rx_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !rx_done) |=> !rx_full);

    // R8
    rx_irq_chk: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> rx_full);

    // R10
    err_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_err && !rx_done) |=> !(ovr || ferr || perr));

endmodule

bind async_serial_port ser_port_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .txd      (txd),
    .tx_busy  (tx_busy),
    .tx_empty (tx_empty),
    .tx_irq   (tx_irq),
    .rx_full  (rx_full),
    .rx_done  (rx_done),
    .rx_irq   (rx_irq),
    .rd_data  (rd_data),
    .clr_err  (clr_err),
    .ovr      (ovr),
    .ferr     (ferr),
    .perr     (perr)
);

// File: tb/async_serial_port_bench.sv
module async_serial_port_bench;
    localparam int CLK_NS = 10;
    localparam int P_DIV  = 32;   // divider 1 -> tick every 2 clocks
    localparam int P_PIN  = 128;  // ext clock period 8 clocks
    localparam int P_TMR  = 48;   // timer pulse every 3 clocks

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ext_clk = 1'b0;
    logic       tmr_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       txd, rx_irq, tx_irq;

    int  checks = 0;
    int  errors = 0;
    bit  m_tx_en = 1'b0;   // model: transmit enable
    bit  ext_run = 1'b0;
    bit  tmr_run = 1'b0;
    int  tmr_cnt = 0;

    always #(CLK_NS/2) clk = ~clk;

    async_serial_port u_async_serial_port (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ext_clk(ext_clk), .tmr_tick(tmr_tick),
        .rxd(rxd), .txd(txd), .rx_irq(rx_irq), .tx_irq(tx_irq)
    );

    initial forever begin
        #(4*CLK_NS);
        ext_clk = ext_run ? ~ext_clk : 1'b0;
    end

    always @(posedge clk) begin
        tmr_cnt  <= (tmr_cnt == 2) ? 0 : tmr_cnt + 1;
        tmr_tick <= tmr_run && (tmr_cnt == 2);
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R11 model comparison every clock: line idle high while model says disabled
    always @(negedge clk) begin
        if (!rst && !m_tx_en) check("R11 txd idle", txd, 1'b1);
    end

    task automatic wreg(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [7:0] d);
        @(posedge clk); #1;
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        d = rdata;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    function automatic int frame_len(input int nb, input bit pen, input bit two);
        return 2 + nb + int'(pen) + int'(two);
    endfunction

    function automatic logic [15:0] mk_line(input logic [7:0] d, input int nb,
                                            input bit pen, input bit odd, input bit msb);
        logic [15:0] l;
        logic [7:0]  m;
        int          p;
        l = '1;
        l[0] = 1'b0;
        p = 1;
        for (int i = 0; i < nb; i++) begin
            l[p] = msb ? d[nb-1-i] : d[i];
            p++;
        end
        m = (nb == 8) ? d : {1'b0, d[6:0]};
        if (pen) l[p] = (^m) ^ odd;
        return l;
    endfunction

    task automatic capture(input int per, input int len, output logic [15:0] line);
        int waited;
        line = '1;
        waited = 0;
        while (txd !== 1'b0 && waited < 4000) begin
            @(negedge clk);
            waited++;
        end
        repeat (per/2) @(negedge clk);
        line[0] = txd;
        for (int i = 1; i < len; i++) begin
            repeat (per) @(negedge clk);
            line[i] = txd;
        end
        repeat (per) @(negedge clk);
    endtask

    task automatic send(input int per, input logic [7:0] d, input int nb, input bit pen,
                        input bit odd, input bit msb, input bit bad_par, input bit stop_lvl);
        logic [15:0] l;
        int          len;
        l = mk_line(d, nb, pen, odd, msb);
        if (pen && bad_par) l[1+nb] = ~l[1+nb];
        l[1+nb+int'(pen)] = stop_lvl;
        len = 2 + nb + int'(pen);
        for (int i = 0; i < len; i++) begin
            @(posedge clk); #1;
            rxd = l[i];
            repeat (per-1) @(posedge clk);
        end
        @(posedge clk); #1;
        rxd = 1'b1;
        repeat (per) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0]  v;
        logic [15:0] line;
        int          len;

        repeat (3) @(posedge clk); #1;
        rst = 1'b0;

        // R1 reset state
        rreg(3'd3, v); check("R1 status", v, 8'h08);
        rreg(3'd2, v); check("R1 control", v, 8'h20);
        rreg(3'd0, v); check("R1 source", v, 8'h00);
        check("R1 txd", txd, 1'b1);
        check("R1 irqs", {rx_irq, tx_irq}, 2'b00);

        // R11 / R7: disabled transmitter holds data pending and line high
        wreg(3'd1, 8'd1);
        wreg(3'd4, 8'hA5);
        repeat (100) @(posedge clk);
        rreg(3'd3, v); check("R7 empty cleared by write", v[3], 1'b0);

        // R3 R2: enable 8N1 LSB-first, pending byte goes out
        m_tx_en = 1'b1;
        wreg(3'd2, 8'h21);
        capture(P_DIV, 10, line);
        check("R3 8N1 lsb frame", line[9:0], mk_line(8'hA5, 8, 0, 0, 0) & 16'h03FF);
        rreg(3'd3, v); check("R7 empty after load", v[3], 1'b1);

        // R4 R5 R6: 7 data bits, even parity, two stops, MSB first
        wreg(3'd3, 8'h01);
        wreg(3'd2, 8'h15);
        wreg(3'd4, 8'h5B);
        len = frame_len(7, 1, 1);
        capture(P_DIV, len, line);
        check("R4 R5 R6 7E2 msb frame", line & 16'h07FF, mk_line(8'h5B, 7, 1, 0, 1) & 16'h07FF);

        // R5 odd parity, 8 bits, LSB first
        wreg(3'd3, 8'h00);
        wreg(3'd2, 8'h2D);
        wreg(3'd4, 8'h3C);
        capture(P_DIV, frame_len(8, 1, 0), line);
        check("R5 8O1 frame", line[10:0], mk_line(8'h3C, 8, 1, 1, 0) & 16'h07FF);

        // R7 tx_irq follows empty and enable
        wreg(3'd3, 8'h04);
        @(negedge clk); check("R7 tx_irq", tx_irq, 1'b1);
        wreg(3'd2, 8'h20); m_tx_en = 1'b0;
        wreg(3'd4, 8'h11);
        @(negedge clk); check("R7 tx_irq low when full", tx_irq, 1'b0);
        wreg(3'd3, 8'h00);

        // R2 external pin source
        wreg(3'd0, 8'h01);
        ext_run = 1'b1;
        m_tx_en = 1'b1;
        wreg(3'd2, 8'h21);
        capture(P_PIN, 10, line);
        check("R2 pin source frame", line[9:0], mk_line(8'h11, 8, 0, 0, 0) & 16'h03FF);

        // R2 timer source
        ext_run = 1'b0;
        wreg(3'd0, 8'h02);
        tmr_run = 1'b1;
        wreg(3'd4, 8'hC3);
        capture(P_TMR, 10, line);
        check("R2 timer source frame", line[9:0], mk_line(8'hC3, 8, 0, 0, 0) & 16'h03FF);
        tmr_run = 1'b0;
        wreg(3'd0, 8'h00);

        // R8 receive 8N1 with interrupt
        wreg(3'd2, 8'h23);
        wreg(3'd3, 8'h02);
        send(P_DIV, 8'h96, 8, 0, 0, 0, 0, 1);
        @(negedge clk); check("R8 rx_irq", rx_irq, 1'b1);
        rreg(3'd3, v); check("R8 rx full no errors", v[7:4], 4'b0001);
        rreg(3'd4, v); check("R8 rx data", v, 8'h96);
        rreg(3'd3, v); check("R8 read clears full", v[4], 1'b0);
        check("R8 rx_irq cleared", rx_irq, 1'b0);

        // R6 R4 receive MSB-first 7 bits
        wreg(3'd3, 8'h01);
        wreg(3'd2, 8'h03);
        send(P_DIV, 8'h4D, 7, 0, 0, 1, 0, 1);
        rreg(3'd4, v); check("R6 msb 7-bit rx", v, 8'h4D);
        wreg(3'd3, 8'h00);

        // R9 short low pulse rejected
        wreg(3'd2, 8'h23);
        @(posedge clk); #1; rxd = 1'b0;
        repeat (6) @(posedge clk); #1; rxd = 1'b1;
        repeat (80) @(posedge clk);
        rreg(3'd3, v); check("R9 glitch ignored", v[4], 1'b0);
        send(P_DIV, 8'h0F, 8, 0, 0, 0, 0, 1);
        rreg(3'd4, v); check("R9 next frame intact", v, 8'h0F);

        // R10 parity error (even parity, wrong bit)
        wreg(3'd2, 8'h27);
        send(P_DIV, 8'h71, 8, 1, 0, 0, 1, 1);
        rreg(3'd3, v); check("R10 parity error", v[7:5], 3'b100);
        rreg(3'd4, v);
        wreg(3'd2, 8'h67);
        rreg(3'd3, v); check("R10 clear", v[7:5], 3'b000);

        // R10 framing error
        send(P_DIV, 8'h22, 8, 1, 0, 0, 0, 0);
        rreg(3'd3, v); check("R10 framing error", v[7:5], 3'b010);
        rreg(3'd4, v);
        wreg(3'd2, 8'h63);

        // R10 overrun: second frame before read
        send(P_DIV, 8'hAA, 8, 0, 0, 0, 0, 1);
        send(P_DIV, 8'h55, 8, 0, 0, 0, 0, 1);
        rreg(3'd3, v); check("R10 overrun", v[7:4], 4'b0011);
        rreg(3'd4, v); check("R10 newer byte kept", v, 8'h55);
        wreg(3'd2, 8'h61);

        // R11 receiver disabled ignores traffic
        send(P_DIV, 8'hE7, 8, 0, 0, 0, 0, 1);
        rreg(3'd3, v); check("R11 rx disabled", v[7:4], 4'b0000);

        finish_run();
    end

endmodule